// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog counter that gives software two chances to recover. When the timer is enabled and nobody kicks it, the first stage counts down from its own preload and then raises a warning interrupt. The interrupt is a level output that can be steered to either a normal interrupt pin or a system-management interrupt pin. The counter then reloads from a second preload and counts down again. If that second stage also expires, the block issues a one-cycle reset request and records the event in a flag that survives the system reset it triggers.

The timebase is a prescaler. One configuration bit selects a microsecond tick or a millisecond tick. With 20-bit preloads, the timeout can be set anywhere from one microsecond to well past ten minutes.

All programming goes through a plain synchronous register port. Word-addressed writes take effect at the clock edge, and read data is combinational from the word index. Preloads and configuration are write-protected. Two key writes to the reload word open the bank for exactly one protected write. A lock bit freezes the protected registers until power-on reset.

There is no streaming data path. Every pin is a plain control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `wdog_two_stage`

## Requirements
- R1: After power-on reset, every readable word reads 0 and `irq_out`, `smi_out` and `rst_req` are low.
- R2: Writes to the protected words are ignored unless the bank is open. The protected words are PRE1 (index 0), PRE2 (index 1) and CONFIG (index 4). The bank opens only after two writes to RELOAD (index 3), data[7:0]=80h and then 86h, with no other write between them. Status bit3 (index 2) reads 1 while the bank is open.
- R3: The first write of any kind after the bank opens closes it again, so only one protected write is accepted per unlock.
- R4: When the timer is enabled (CONFIG bit0), stage 1 lasts PRE1 ticks and is counted from the enabling write or the last reload. Its expiry sets status bit0, sets status bit2 (second stage running) and starts stage 2 from PRE2.
- R5: While status bit0 is 1 and CONFIG bit2 (interrupt enable) is set, `irq_out` is high when CONFIG bit4 is 0, and `smi_out` is high when CONFIG bit4 is 1. The two pins are never high together.
- R6: Stage 2 lasts PRE2 ticks. On expiry, `rst_req` pulses for exactly one cycle if CONFIG bit3 (reset enable) is set, and status bit1 (reset cause) is set. The counter then restarts stage 1.
- R7: Any write to RELOAD whose data[7:0] is not a key value restarts stage 1 from PRE1, restarts the prescaler and clears status bit0.
- R8: CONFIG bit1=0 gives one tick per CLKS_PER_US clocks. CONFIG bit1=1 gives one tick per CLKS_PER_US*US_PER_MS clocks.
- R9: Writing 1 to status bit0 or bit1 clears that bit. Writing 0 to a bit leaves it unchanged.
- R10: The reset-cause bit survives `rst_n`. It is cleared only by writing 1 to it or by `por_n`.
- R11: Once CONFIG bit5 (lock) is set, writes to PRE1, PRE2 and CONFIG are ignored even after a correct unlock. `rst_n` does not release the lock; only `por_n` does. Preloads and CONFIG are otherwise also kept through `rst_n`.
- R12: A preload of 0 behaves as one tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including lock and reset cause |
| rst_n | input | 1 | System reset, active low; clears counter, prescaler, unlock state and warning flag |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word index: 0 PRE1, 1 PRE2, 2 STATUS, 3 RELOAD, 4 CONFIG, 5 COUNT (read only) |
| bus_wdata | input | PRE_W | Write data |
| bus_rdata | output | PRE_W | Read data for the word at `bus_addr` |
| irq_out | output | 1 | Warning interrupt, normal-interrupt variant |
| smi_out | output | 1 | Warning interrupt, system-management variant |
| rst_req | output | 1 | One-cycle reset request on second-stage expiry |

## Verification
The timing paths are driven with random preload pairs from 0 to 5, random tick selection, interrupt pin selection and enable bits. The expiry edges are predicted to the cycle, with the cycle before each expiry checked as well. This separates an off-by-one tick count from a correct one, and it separates a preload of zero from one.

Directed sequences cover the protection logic:
- a broken key pair;
- a second write after an unlock;
- a locked bank;
- reload mid-stage, which shows that the count restarts rather than continues;
- the write-one-to-clear bits;
- a system reset against a power-on reset, which shows which state each one clears.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int IDX_W = 3;

  localparam logic [IDX_W-1:0] IDX_PRE1   = 3'd0;
  localparam logic [IDX_W-1:0] IDX_PRE2   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_STATUS = 3'd2;
  localparam logic [IDX_W-1:0] IDX_RELOAD = 3'd3;
  localparam logic [IDX_W-1:0] IDX_CONFIG = 3'd4;
  localparam logic [IDX_W-1:0] IDX_COUNT  = 3'd5;

  localparam logic [7:0] KEY_ARM  = 8'h80;
  localparam logic [7:0] KEY_OPEN = 8'h86;

  typedef struct packed {
    logic lock;     // bit5
    logic smi_sel;  // bit4
    logic rst_en;   // bit3
    logic irq_en;   // bit2
    logic tick_ms;  // bit1
    logic enable;   // bit0
  } cfg_t;

  typedef enum logic [1:0] {KS_IDLE, KS_ARMED, KS_OPEN} key_state_e;
  typedef enum logic {ST_WARN, ST_FINAL} stage_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int CLKS_PER_US = 250,
  parameter int US_PER_MS   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick_ms,
  output logic tick
);
  localparam int UW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam int MW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;

  logic us_tick;
  logic ms_tick;
  logic [MW-1:0] ms_cnt;

  generate
    if (CLKS_PER_US > 1) begin : g_us_div
      logic [UW-1:0] us_cnt;
      assign us_tick = (us_cnt == UW'(CLKS_PER_US - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       us_cnt <= '0;
        else if (restart) us_cnt <= '0;
        else if (us_tick) us_cnt <= '0;
        else              us_cnt <= us_cnt + 1'b1;
      end
    end else begin : g_us_direct
      assign us_tick = 1'b1;
    end
  endgenerate

  assign ms_tick = us_tick && (ms_cnt == MW'(US_PER_MS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ms_cnt <= '0;
    else if (restart) ms_cnt <= '0;
    else if (ms_tick) ms_cnt <= '0;
    else if (us_tick) ms_cnt <= ms_cnt + 1'b1;
  end

  assign tick = tick_ms ? ms_tick : us_tick;
endmodule

// File: rtl/wdt_stage_counter.sv
module wdt_stage_counter
  import wdt_pkg::*;
#(
  parameter int PRE_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             reload,
  input  logic [PRE_W-1:0] pre1,
  input  logic [PRE_W-1:0] pre2,
  output logic [PRE_W-1:0] count,
  output stage_e           stage,
  output logic             expire1,
  output logic             expire2
);
  logic expire;

  // A count of 0 or 1 ends the stage on the next tick, so preload 0 acts as 1.
  assign expire  = enable && !reload && tick && (count <= PRE_W'(1));
  assign expire1 = expire && (stage == ST_WARN);
  assign expire2 = expire && (stage == ST_FINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      stage <= ST_WARN;
    end else if (!enable || reload) begin
      count <= pre1;
      stage <= ST_WARN;
    end else if (tick) begin
      if (expire1) begin
        count <= pre2;
        stage <= ST_FINAL;
      end else if (expire2) begin
        count <= pre1;
        stage <= ST_WARN;
      end else begin
        count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_regbank.sv
module wdt_regbank
  import wdt_pkg::*;
#(
  parameter int PRE_W = 20
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             bus_wr,
  input  logic [IDX_W-1:0] bus_addr,
  input  logic [PRE_W-1:0] bus_wdata,
  output logic [PRE_W-1:0] bus_rdata,
  input  logic             expire1,
  input  logic             expire2,
  input  stage_e           stage,
  input  logic [PRE_W-1:0] count,
  output logic [PRE_W-1:0] pre1,
  output logic [PRE_W-1:0] pre2,
  output cfg_t             cfg,
  output logic             irq_flag,
  output logic             cause_flag,
  output logic             unlocked,
  output logic             reload
);
  key_state_e key_q;
  logic wr_key, key_arm, key_open, prot_ok, wr_status;

  assign wr_key    = bus_wr && (bus_addr == IDX_RELOAD);
  assign key_arm   = wr_key && (bus_wdata[7:0] == KEY_ARM);
  assign key_open  = wr_key && (bus_wdata[7:0] == KEY_OPEN) && (key_q == KS_ARMED);
  assign reload    = wr_key && !key_arm && !key_open;
  assign wr_status = bus_wr && (bus_addr == IDX_STATUS);
  assign unlocked  = (key_q == KS_OPEN);
  assign prot_ok   = unlocked && !cfg.lock;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)    key_q <= KS_IDLE;
    else if (bus_wr) begin
      if (key_arm)       key_q <= KS_ARMED;
      else if (key_open) key_q <= KS_OPEN;
      else               key_q <= KS_IDLE;
    end
  end

  // Settings live on the power-on domain so a watchdog reset keeps them.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pre1 <= '0;
      pre2 <= '0;
      cfg  <= '0;
    end else if (bus_wr && prot_ok) begin
      case (bus_addr)
        IDX_PRE1:   pre1 <= bus_wdata;
        IDX_PRE2:   pre2 <= bus_wdata;
        IDX_CONFIG: cfg  <= cfg_t'(bus_wdata[5:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                          cause_flag <= 1'b0;
    else if (expire2 && cfg.rst_en)      cause_flag <= 1'b1;
    else if (wr_status && bus_wdata[1])  cause_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)                      irq_flag <= 1'b0;
    else if (expire1)                    irq_flag <= 1'b1;
    else if (reload)                     irq_flag <= 1'b0;
    else if (wr_status && bus_wdata[0])  irq_flag <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IDX_PRE1:   bus_rdata = pre1;
      IDX_PRE2:   bus_rdata = pre2;
      IDX_STATUS: bus_rdata = {{(PRE_W-4){1'b0}}, unlocked, (stage == ST_FINAL),
                               cause_flag, irq_flag};
      IDX_CONFIG: bus_rdata = {{(PRE_W-6){1'b0}}, cfg};
      IDX_COUNT:  bus_rdata = count;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdt_pkg::*;
#(
  parameter int CLKS_PER_US = 250,
  parameter int US_PER_MS   = 1000,
  parameter int PRE_W       = 20
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [IDX_W-1:0] bus_addr,
  input  logic [PRE_W-1:0] bus_wdata,
  output logic [PRE_W-1:0] bus_rdata,
  output logic             irq_out,
  output logic             smi_out,
  output logic             rst_req
);
  logic             sys_rst_n;
  logic             tick, reload, expire1, expire2;
  logic             irq_flag, cause_flag, unlocked;
  logic [PRE_W-1:0] pre1, pre2, count;
  cfg_t             cfg;
  stage_e           stage;

  assign sys_rst_n = rst_n && por_n;

  wdt_prescaler #(.CLKS_PER_US(CLKS_PER_US), .US_PER_MS(US_PER_MS)) u_presc (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .restart (reload || !cfg.enable),
    .tick_ms (cfg.tick_ms),
    .tick    (tick)
  );

  wdt_stage_counter #(.PRE_W(PRE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .enable  (cfg.enable),
    .tick    (tick),
    .reload  (reload),
    .pre1    (pre1),
    .pre2    (pre2),
    .count   (count),
    .stage   (stage),
    .expire1 (expire1),
    .expire2 (expire2)
  );

  wdt_regbank #(.PRE_W(PRE_W)) u_regs (
    .clk        (clk),
    .por_n      (por_n),
    .sys_rst_n  (sys_rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .expire1    (expire1),
    .expire2    (expire2),
    .stage      (stage),
    .count      (count),
    .pre1       (pre1),
    .pre2       (pre2),
    .cfg        (cfg),
    .irq_flag   (irq_flag),
    .cause_flag (cause_flag),
    .unlocked   (unlocked),
    .reload     (reload)
  );

  assign irq_out = irq_flag && cfg.irq_en && !cfg.smi_sel;
  assign smi_out = irq_flag && cfg.irq_en && cfg.smi_sel;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) rst_req <= 1'b0;
    else            rst_req <= expire2 && cfg.rst_en;
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int PRE_W = 20
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             rst_req,
  input logic             irq_out,
  input logic             smi_out,
  input logic             cause_flag,
  input logic             cfg_lock,
  input logic             unlocked,
  input logic             bus_wr,
  input logic [IDX_W-1:0] bus_addr,
  input logic [PRE_W-1:0] pre1,
  input logic [PRE_W-1:0] pre2
);
  p_pulse_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rst_req |=> !rst_req);

  p_cause_set_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rst_req |-> cause_flag);

  p_pin_excl_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !(irq_out && smi_out));

  p_lock_hold_r11: assert property (@(posedge clk) disable iff (!por_n)
    cfg_lock |=> cfg_lock);

  p_lock_freeze_r11: assert property (@(posedge clk) disable iff (!por_n)
    cfg_lock |=> ($stable(pre1) && $stable(pre2)));

  p_guard_r2: assert property (@(posedge clk) disable iff (!por_n)
    (bus_wr && bus_addr == IDX_PRE1 && !unlocked) |=> $stable(pre1));
endmodule

bind wdog_two_stage wdt_checker #(.PRE_W(PRE_W)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .sys_rst_n  (sys_rst_n),
  .rst_req    (rst_req),
  .irq_out    (irq_out),
  .smi_out    (smi_out),
  .cause_flag (cause_flag),
  .cfg_lock   (cfg.lock),
  .unlocked   (unlocked),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .pre1       (pre1),
  .pre2       (pre2)
);

// File: tb/tb_wdog_two_stage.sv
`timescale 1ns/100ps
module tb_wdog_two_stage;
  localparam int CPU = 4;
  localparam int UPM = 5;
  localparam int PW  = 20;

  logic          clk = 1'b0;
  logic          por_n, rst_n, bus_wr;
  logic [2:0]    bus_addr;
  logic [PW-1:0] bus_wdata, bus_rdata;
  logic          irq_out, smi_out, rst_req;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdog_two_stage #(.CLKS_PER_US(CPU), .US_PER_MS(UPM), .PRE_W(PW)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .smi_out(smi_out), .rst_req(rst_req));

  function automatic int stage_cycles(int pre, bit ms);
    int t = (pre < 1) ? 1 : pre;
    return t * (ms ? CPU * UPM : CPU);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] idx, int data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = idx; bus_wdata = PW'(data);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic uwr(logic [2:0] idx, int data);
    wr(3'd3, 32'h80);
    wr(3'd3, 32'h86);
    wr(idx, data);
  endtask

  task automatic rd(logic [2:0] idx, output int v);
    bus_addr = idx;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic pulse_reset(bit por);
    @(negedge clk);
    if (por) por_n = 1'b0; else rst_n = 1'b0;
    step(2);
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  task automatic run_case(int p1, int p2, bit ms, bit smi, bit ien, bit ren);
    int v;
    int c;
    uwr(3'd4, 0);
    wr(3'd2, 3);
    uwr(3'd0, p1);
    uwr(3'd1, p2);
    c = 1 | (int'(ms) << 1) | (int'(ien) << 2) | (int'(ren) << 3) | (int'(smi) << 4);
    uwr(3'd4, c);
    step(stage_cycles(p1, ms) - 1);
    chk("R4 R8 R12 warn early", int'(irq_out | smi_out), 0);
    step(1);
    chk("R5 irq pin", int'(irq_out), int'(ien & !smi));
    chk("R5 smi pin", int'(smi_out), int'(ien & smi));
    rd(3'd2, v);
    chk("R4 status flag+stage", v & 5, 5);
    step(stage_cycles(p2, ms) - 1);
    chk("R6 R12 rst early", int'(rst_req), 0);
    step(1);
    chk("R6 rst_req pulse", int'(rst_req), int'(ren));
    step(1);
    chk("R6 rst_req one cycle", int'(rst_req), 0);
    rd(3'd2, v);
    chk("R6 cause flag", (v >> 1) & 1, int'(ren));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    int p1;
    int p2;
    bit ms;
    por_n = 1'b0; rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    step(3);
    por_n = 1'b1; rst_n = 1'b1;
    step(1);

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), v);
      chk("R1 word after por", v, 0);
    end
    chk("R1 pins", int'({irq_out, smi_out, rst_req}), 0);

    // R2 guarded writes
    wr(3'd0, 7);
    rd(3'd0, v); chk("R2 write without unlock", v, 0);
    wr(3'd3, 32'h80); wr(3'd2, 0); wr(3'd3, 32'h86);
    rd(3'd2, v); chk("R2 broken key pair", (v >> 3) & 1, 0);
    wr(3'd0, 9);
    rd(3'd0, v); chk("R2 broken key pair write", v, 0);
    wr(3'd3, 32'h80); wr(3'd3, 32'h86);
    rd(3'd2, v); chk("R2 open flag", (v >> 3) & 1, 1);
    wr(3'd0, 9);
    rd(3'd0, v); chk("R2 unlocked write", v, 9);
    // R3 one write per unlock
    rd(3'd2, v); chk("R3 closed after write", (v >> 3) & 1, 0);
    wr(3'd0, 5);
    rd(3'd0, v); chk("R3 second write ignored", v, 9);

    // directed expiry cases: us and ms ticks, zero preload
    run_case(3, 2, 1'b0, 1'b0, 1'b1, 1'b1);
    run_case(2, 1, 1'b1, 1'b1, 1'b1, 1'b1);
    run_case(0, 0, 1'b0, 1'b0, 1'b1, 1'b1);

    // R10 cause survives system reset
    pulse_reset(1'b0);
    rd(3'd2, v); chk("R10 cause after rst_n", v & 3, 2);
    wr(3'd2, 0);
    rd(3'd2, v); chk("R9 write zero keeps", (v >> 1) & 1, 1);
    wr(3'd2, 2);
    rd(3'd2, v); chk("R9 R10 w1c cause", (v >> 1) & 1, 0);

    // R7 reload and R9 warning clear
    uwr(3'd4, 0);
    uwr(3'd0, 3);
    uwr(3'd1, 5);
    uwr(3'd4, 32'h05);
    step(6);
    wr(3'd3, 0);
    step(11);
    chk("R7 restart early", int'(irq_out), 0);
    step(1);
    chk("R7 restart expiry", int'(irq_out), 1);
    wr(3'd2, 2);
    chk("R9 other bit no clear", int'(irq_out), 1);
    wr(3'd2, 1);
    chk("R9 w1c warning", int'(irq_out), 0);
    step(40);
    chk("R4 warning again", int'(irq_out), 1);
    wr(3'd3, 32'h12);
    rd(3'd2, v); chk("R7 reload clears flag+stage", v & 5, 0);
    chk("R7 pin after reload", int'(irq_out), 0);

    // R10 power-on clears cause
    run_case(1, 1, 1'b0, 1'b1, 1'b0, 1'b1);
    pulse_reset(1'b1);
    rd(3'd2, v); chk("R10 cause after por", v, 0);

    // R11 lock
    uwr(3'd0, 4);
    uwr(3'd4, 32'h20);
    rd(3'd4, v); chk("R11 lock set", v, 32'h20);
    uwr(3'd0, 32'h33);
    rd(3'd0, v); chk("R11 preload frozen", v, 4);
    uwr(3'd4, 0);
    rd(3'd4, v); chk("R11 config frozen", v, 32'h20);
    pulse_reset(1'b0);
    rd(3'd4, v); chk("R11 lock survives rst_n", v, 32'h20);
    pulse_reset(1'b1);
    rd(3'd4, v); chk("R11 por releases", v, 0);

    // constrained random expiry cases
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 16; i++) begin
      p1 = int'($urandom % 6);
      p2 = int'($urandom % 6);
      ms = ($urandom % 4) == 0;
      run_case(p1, p2, ms, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule